// File: doc/BRIEF.md
# Programmable Quadrature Bin Clock Generator

This block turns a fast system clock into the timing for a counting instrument that records data in bins. A chain of binary dividers produces a pulse one system clock wide. The division ratio of the chain is chosen by two programming codes. That pulse steps a two-bit Gray phase counter, which gives four outputs a quarter period apart. All four are resampled on the system clock. One of them is the bin clock, and each of its half-periods is one counting bin.

Each change of the bin clock is a bin boundary. At every boundary the block issues a fixed sequence of one-cycle strobes: first a latch strobe to capture the count of the bin that just ended, then a write strobe to store it, then a clear strobe to reset the counter. With a 100 MHz clock and the fastest setting, a bin is 40 ns and the bin clock runs at 12.5 MHz. At the slowest setting a pulse comes about every 10.5 ms.

The programming codes are taken only while the generator is stopped. Deasserting the enable stops the generator and clears every divider and phase register.

Top module: `bin_clock_gen`

## Requirements
- R1: After reset, and on the first clock edge that samples the enable low, every output is 0.
- R2: A prescale code c of 0 to 4 gives a prescale ratio of 2^(c+1), which is 2, 4, 8, 16 or 32.
- R3: Prescale codes 5, 6 and 7 are reserved and give the slowest prescale ratio, 32.
- R4: A post code n of 0 bypasses the second stage (ratio 1). A post code n of 1 to 15 gives a ratio of 2^n. The pulse period P, in clock cycles, is the prescale ratio times the post ratio.
- R5: Count j as the number of rising edges that have sampled the enable high, and let ph = floor((j-2)/P) mod 4 for j >= 2, and ph = 0 otherwise. For j >= 1, let a = ph[1] and b = ph[1] XOR ph[0]. Then quad_o is {~b, ~a, b, a}, with quad_o[0] in bit 0, and bin_clk_o equals quad_o[0]. So the bin clock changes every 2P cycles, and a bin is 4 cycles (40 ns) at the fastest setting.
- R6: bin_start_o is high for exactly the one cycle in which bin_clk_o differs from its value one edge earlier.
- R7: latch_o, write_o and clear_o follow bin_start_o by 1, 2 and 3 cycles, in that order. Each is one cycle wide, and no two of the four outputs bin_start_o, latch_o, write_o and clear_o are ever high together.
- R8: The prescale and post codes are sampled only while the enable is low. A change of either code while running has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the generator and loads the codes |
| pre_sel_i | input | 3 | Prescale ratio code |
| post_sel_i | input | 4 | Second-stage exponent code |
| bin_clk_o | output | 1 | Bin clock; each half-period is one bin |
| quad_o | output | 4 | Resampled quadrature phases |
| bin_start_o | output | 1 | One-cycle bin boundary mark |
| latch_o | output | 1 | Count latch strobe |
| write_o | output | 1 | Memory write strobe |
| clear_o | output | 1 | Counter reset strobe |

## Verification
The checker assumes that the enable is held low while reset is active, so the first sampled past value of the enable is a known low. It makes no assumption about when the codes change, because the design must ignore any change that happens while it is running. The stimulus drives the enable low through reset and moves it only at falling edges. It picks both codes at random, and includes the reserved prescale codes, but only from ranges that keep P small enough for several bins to finish within the run. Directed runs cover the fastest setting, a reserved prescale code, a long post stage, and a change of the codes in the middle of a run.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int PRE_W      = 3;
    localparam int POST_W     = 4;
    localparam int PRE_STAGES = 5;
    localparam int POST_MAX   = 15;
    localparam int CNT_W      = PRE_STAGES + POST_MAX;
    localparam int SHIFT_W    = $clog2(CNT_W + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    // Number of divide-by-2 prescale stages; reserved codes give the slowest ratio
    function automatic logic [SHIFT_W-1:0] pre_bits(input logic [PRE_W-1:0] code);
        if (int'(code) < PRE_STAGES)
            pre_bits = SHIFT_W'(int'(code) + 1);
        else
            pre_bits = SHIFT_W'(PRE_STAGES);
    endfunction

    // Number of divide-by-2 stages in the second stage (0 = bypassed)
    function automatic logic [SHIFT_W-1:0] post_bits(input logic [POST_W-1:0] code);
        if (int'(code) <= POST_MAX)
            post_bits = SHIFT_W'(code);
        else
            post_bits = SHIFT_W'(POST_MAX);
    endfunction

endpackage

// File: rtl/bcg_divider.sv
module bcg_divider
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [PRE_W-1:0]  pre_sel_i,
    input  logic [POST_W-1:0] post_sel_i,
    output logic              pulse_o
);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
        cnt_t              cnt;
        logic              pulse;
    } div_st_t;

    div_st_t st_d, st_q;
    cnt_t    mask;
    logic [SHIFT_W-1:0] span;

    always_comb begin
        span = pre_bits(st_q.pre) + post_bits(st_q.post);
        for (int i = 0; i < CNT_W; i++)
            mask[i] = (i < int'(span));
    end

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.pre   = pre_sel_i;
            st_d.post  = post_sel_i;
            st_d.cnt   = '0;
            st_d.pulse = 1'b0;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.pulse = ((st_q.cnt & mask) == mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/bcg_quad.sv
module bcg_quad (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       pulse_i,
    output logic [3:0] quad_o
);

    typedef struct packed {
        logic [1:0] ph;
        logic [3:0] qs;
    } quad_st_t;

    quad_st_t st_d, st_q;
    logic qa, qb;

    always_comb begin
        qa = st_q.ph[1];
        qb = st_q.ph[1] ^ st_q.ph[0];
        st_d = st_q;
        if (!en_i) begin
            st_d.ph = '0;
            st_d.qs = '0;
        end else begin
            if (pulse_i) st_d.ph = st_q.ph + 2'd1;
            st_d.qs = {~qb, ~qa, qb, qa};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quad_o = st_q.qs;

endmodule

// File: rtl/bcg_strobe.sv
module bcg_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bin_clk_i,
    output logic start_o,
    output logic latch_o,
    output logic write_o,
    output logic clear_o
);

    typedef struct packed {
        logic prev;
        logic latch;
        logic write;
        logic clear;
    } stb_st_t;

    stb_st_t st_d, st_q;
    logic    edge_seen;

    assign edge_seen = bin_clk_i ^ st_q.prev;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.prev  = bin_clk_i;
            st_d.latch = edge_seen;
            st_d.write = st_q.latch;
            st_d.clear = st_q.write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = edge_seen;
    assign latch_o = st_q.latch;
    assign write_o = st_q.write;
    assign clear_o = st_q.clear;

endmodule

// File: rtl/bin_clock_gen.sv
module bin_clock_gen
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [PRE_W-1:0]  pre_sel_i,
    input  logic [POST_W-1:0] post_sel_i,
    output logic              bin_clk_o,
    output logic [3:0]        quad_o,
    output logic              bin_start_o,
    output logic              latch_o,
    output logic              write_o,
    output logic              clear_o
);

    logic pulse;

    bcg_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .pre_sel_i  (pre_sel_i),
        .post_sel_i (post_sel_i),
        .pulse_o    (pulse)
    );

    bcg_quad u_quad (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .pulse_i (pulse),
        .quad_o  (quad_o)
    );

    assign bin_clk_o = quad_o[0];

    bcg_strobe u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .bin_clk_i (quad_o[0]),
        .start_o   (bin_start_o),
        .latch_o   (latch_o),
        .write_o   (write_o),
        .clear_o   (clear_o)
    );

endmodule

// File: rtl/bin_clock_gen_chk.sv
module bin_clock_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       bin_clk_o,
    input logic [3:0] quad_o,
    input logic       bin_start_o,
    input logic       latch_o,
    input logic       write_o,
    input logic       clear_o
);

    a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_i) |-> (quad_o == 4'b0 && !bin_clk_o && !bin_start_o &&
                          !latch_o && !write_o && !clear_o));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bin_start_o, latch_o, write_o, clear_o}));

    a_r7_latch_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o && en_i) |=> write_o);

    a_r7_write_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (write_o && en_i) |=> clear_o);

    a_r5_quad_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_o != 4'b0) |-> (quad_o[3:2] == ~quad_o[1:0]));

    a_r5_one_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && en_i && quad_o != 4'b0 && $past(quad_o) != 4'b0)
            |-> ($countones(quad_o[1:0] ^ $past(quad_o[1:0])) <= 1));

endmodule

bind bin_clock_gen bin_clock_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .bin_clk_o   (bin_clk_o),
    .quad_o      (quad_o),
    .bin_start_o (bin_start_o),
    .latch_o     (latch_o),
    .write_o     (write_o),
    .clear_o     (clear_o)
);

// File: tb/bin_clock_gen_tb.sv
module bin_clock_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [2:0] pre_sel_i = '0;
    logic [3:0] post_sel_i = '0;
    logic       bin_clk_o, bin_start_o, latch_o, write_o, clear_o;
    logic [3:0] quad_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bin_clock_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .pre_sel_i(pre_sel_i), .post_sel_i(post_sel_i),
        .bin_clk_o(bin_clk_o), .quad_o(quad_o), .bin_start_o(bin_start_o),
        .latch_o(latch_o), .write_o(write_o), .clear_o(clear_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 200000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // R2, R3, R4: pulse period
    function automatic longint period(input int pre, input int post);
        int p;
        p = (pre < 5) ? pre + 1 : 5;
        return longint'(1) << (p + post);
    endfunction

    // R5: expected quadrature vector after edge j
    function automatic logic [3:0] exp_quad(input longint j, input longint p);
        logic [1:0] ph;
        logic a, b;
        if (j < 1) return 4'b0;
        ph = (j >= 2) ? 2'(((j - 2) / p) % 4) : 2'd0;
        a = ph[1];
        b = ph[1] ^ ph[0];
        return {~b, ~a, b, a};
    endfunction

    // R6: expected boundary mark after edge j
    function automatic logic exp_start(input longint j, input longint p);
        if (j < 1) return 1'b0;
        return exp_quad(j, p)[0] ^ exp_quad(j - 1, p)[0];
    endfunction

    // R7: expected {start, latch, write, clear}
    function automatic logic [3:0] exp_stb(input longint j, input longint p);
        return {exp_start(j, p), exp_start(j - 1, p), exp_start(j - 2, p), exp_start(j - 3, p)};
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] outs();
        return {bin_clk_o, quad_o, bin_start_o, latch_o, write_o, clear_o};
    endfunction

    // Run one enabled stretch; optionally change codes mid-run (R8)
    task automatic run_case(input string tag, input int pre, input int post,
                            input longint n, input bit poke);
        longint p;
        p = period(pre, post);
        pre_sel_i  = 3'(pre);
        post_sel_i = 4'(post);
        @(negedge clk);
        en_i = 1'b1;
        for (longint j = 1; j <= n; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && j == 5) begin
                pre_sel_i  = 3'(pre ^ 1);
                post_sel_i = 4'(post ^ 3);
            end
            check(tag, outs(), {exp_quad(j, p)[0], exp_quad(j, p), exp_stb(j, p)});
        end
        en_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 stop", outs(), 9'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), 9'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", outs(), 9'b0);

        run_case("R2 R5 R6 R7 fastest", 0, 0, 40, 1'b0);
        run_case("R2 pre4", 4, 0, 4*2*32 + 10, 1'b0);
        run_case("R3 reserved pre6", 6, 0, 4*2*32 + 10, 1'b0);
        run_case("R3 reserved pre7", 7, 1, 4*2*64 + 10, 1'b0);
        run_case("R4 post12", 0, 12, 4*8192 + 10, 1'b0);
        run_case("R8 codes ignored while running", 1, 2, 4*2*16 + 10, 1'b1);

        for (int k = 0; k < 8; k++) begin
            int pr, po;
            pr = int'($urandom % 8);
            po = int'($urandom % 5);
            run_case("R4 R5 random", pr, po, 4*2*period(pr, po) + 10, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule